// File: doc/BRIEF.md
# Two-Write Four-Read Register File with Split-Word Storage

This block is a register file that accepts two writes and serves four reads in every clock cycle. It is built only from simple memories with one write port and one read port each, so it maps onto ordinary inferred block RAM. The second write port is not gained by running the memories faster or by splitting the address space. Instead, every stored word is kept as two parts, one owned by each write port. A read returns the bitwise XOR of the two parts at the requested address.

Each write port owns a group of banks. When a port writes, it first fetches the part that the other port holds at that address. In the next cycle it stores the new data XOR that part into every bank of its own group. The XOR of both parts then equals the new data. One bank in each group answers the other port's fetches, and one bank per read port answers reads. The default build has 32 words of 32 bits, four read ports and ten banks in total.

A write therefore completes one cycle later than a plain memory write. Reads are not forwarded from pending writes. If the two ports write the same address in back-to-back cycles, an internal forward inside the write pipeline keeps the later write's encoding correct.

Top module: `xrf_regfile`

## Requirements
- R1: Both write ports and all four read ports can be used in the same clock cycle, and each acts independently of the others.
- R2: Each read port has one cycle of latency. The word at the address presented in cycle t appears on that port's `rd_data` slice in cycle t+1 and stays there until the next edge.
- R3: A write issued in cycle c is seen by any read whose address is presented in cycle c+2 or later. A read of that address presented in cycle c or c+1 returns the value from before the write.
- R4: When one write port writes an address and the other port writes the same address in the next cycle, the later write's data is the value that remains stored.
- R5: When one port writes the same address in consecutive cycles, the data of the last write is the value that remains stored.
- R6: Two writes in the same cycle to different addresses are both stored. Writing the same address from both ports in one cycle is not allowed.
- R7: A write presented while `rst` is high is discarded. Reset leaves the stored contents unchanged.
- R8: With a port's enable low, its address and data inputs have no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all ports |
| rst | input | 1 | Synchronous active-high reset of the write pipeline |
| wr0_en | input | 1 | Write enable, port 0 |
| wr0_addr | input | AW (5) | Write address, port 0 |
| wr0_data | input | WIDTH (32) | Write data, port 0 |
| wr1_en | input | 1 | Write enable, port 1 |
| wr1_addr | input | AW (5) | Write address, port 1 |
| wr1_data | input | WIDTH (32) | Write data, port 1 |
| rd_addr | input | NRD*AW (20) | Read addresses, slice p for read port p |
| rd_data | output | NRD*WIDTH (128) | Read data, slice p for read port p |

## Verification
The hardest overlaps are a read of an address while that address's write is still in flight, and a fetch of the other port's part in the very cycle that port is storing a new part at the same address. The bench provokes both on purpose. It issues reads of the write address in the write cycle and in the next two cycles, and it issues cross-port writes to one address in consecutive cycles in both orders. It then runs a long random mix with every port active. A behavioural model that applies each write one cycle after it is issued, and answers reads before that edge's updates, judges every read output on every clock.

// File: rtl/xrf_pkg.sv
package xrf_pkg;

  // Number of independent write ports; the split-word scheme here pairs two.
  localparam int WR_PORTS = 2;

  // Each write group needs one bank per read port plus one bank that
  // answers the peer port's part fetch.
  function automatic int banks_per_group(input int n_read);
    return n_read + 1;
  endfunction

  // Peer group index for a two-port arrangement.
  function automatic int peer_of(input int g);
    return (g == 0) ? 1 : 0;
  endfunction

endpackage

// File: rtl/xrf_bank.sv
// Simple memory: one write port, one registered read port, no reset,
// read-before-write when both ports hit the same address on one edge.
module xrf_bank #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/xrf_group.sv
// One write port's bank group and its two-stage write pipeline.
// Stage 1: register the request while the peer's part is fetched.
// Stage 2: store (data XOR peer part) into every bank of this group.
module xrf_group #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  parameter int NRD   = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  // this group's write request
  input  logic                      req_en,
  input  logic [AW-1:0]             req_addr,
  input  logic [WIDTH-1:0]          req_data,
  // fetch service for the peer group
  input  logic [AW-1:0]             lookup_addr,
  output logic [WIDTH-1:0]          lookup_part,
  // peer's fetched part and peer's stage-2 store
  input  logic [WIDTH-1:0]          peer_part,
  input  logic                      peer_commit_en,
  input  logic [AW-1:0]             peer_commit_addr,
  input  logic [WIDTH-1:0]          peer_commit_data,
  // this group's stage-2 store
  output logic                      commit_en,
  output logic [AW-1:0]             commit_addr,
  output logic [WIDTH-1:0]          commit_data,
  // read service
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  output logic [NRD-1:0][WIDTH-1:0] rd_part
);

  localparam int NBANK = xrf_pkg::banks_per_group(NRD);

  logic             s1_valid;
  logic [AW-1:0]    s1_addr;
  logic [WIDTH-1:0] s1_data;
  logic             fwd_hit;
  logic [WIDTH-1:0] fwd_part;
  logic [WIDTH-1:0] other_part;

  // Stage 1 capture. The peer may be storing a new part at our address on
  // the same edge our fetch samples its bank; the bank returns the old part
  // then, so the peer's store value is captured here instead.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= req_en;
    end
    s1_addr  <= req_addr;
    s1_data  <= req_data;
    fwd_hit  <= peer_commit_en && (peer_commit_addr == req_addr);
    fwd_part <= peer_commit_data;
  end

  assign other_part  = fwd_hit ? fwd_part : peer_part;
  assign commit_en   = s1_valid;
  assign commit_addr = s1_addr;
  assign commit_data = s1_data ^ other_part;

  // All banks of the group hold identical contents; they differ only in
  // which reader owns their read port.
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [AW-1:0]    bank_raddr;
    logic [WIDTH-1:0] bank_rdata;

    if (b == NBANK - 1) begin : g_lookup
      assign bank_raddr  = lookup_addr;
      assign lookup_part = bank_rdata;
    end else begin : g_read
      assign bank_raddr = rd_addr[b];
      assign rd_part[b] = bank_rdata;
    end

    xrf_bank #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH),
      .AW    (AW)
    ) u_bank (
      .clk   (clk),
      .we    (commit_en),
      .waddr (commit_addr),
      .wdata (commit_data),
      .raddr (bank_raddr),
      .rdata (bank_rdata)
    );
  end

endmodule

// File: rtl/xrf_regfile.sv
// Two-write four-read register file from 1W1R banks, words held as XOR parts.
module xrf_regfile #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  parameter int NRD   = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr0_en,
  input  logic [AW-1:0]             wr0_addr,
  input  logic [WIDTH-1:0]          wr0_data,
  input  logic                      wr1_en,
  input  logic [AW-1:0]             wr1_addr,
  input  logic [WIDTH-1:0]          wr1_data,
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  output logic [NRD-1:0][WIDTH-1:0] rd_data
);

  localparam int NW = xrf_pkg::WR_PORTS;

  logic [NW-1:0]                     req_en;
  logic [NW-1:0][AW-1:0]             req_addr;
  logic [NW-1:0][WIDTH-1:0]          req_data;
  logic [NW-1:0][WIDTH-1:0]          lookup_part;
  logic [NW-1:0]                     commit_en;
  logic [NW-1:0][AW-1:0]             commit_addr;
  logic [NW-1:0][WIDTH-1:0]          commit_data;
  logic [NW-1:0][NRD-1:0][WIDTH-1:0] part;

  assign req_en   = {wr1_en,   wr0_en};
  assign req_addr = {wr1_addr, wr0_addr};
  assign req_data = {wr1_data, wr0_data};

  for (genvar g = 0; g < NW; g++) begin : g_grp
    localparam int PEER = xrf_pkg::peer_of(g);

    xrf_group #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH),
      .NRD   (NRD),
      .AW    (AW)
    ) u_grp (
      .clk              (clk),
      .rst              (rst),
      .req_en           (req_en[g]),
      .req_addr         (req_addr[g]),
      .req_data         (req_data[g]),
      .lookup_addr      (req_addr[PEER]),
      .lookup_part      (lookup_part[g]),
      .peer_part        (lookup_part[PEER]),
      .peer_commit_en   (commit_en[PEER]),
      .peer_commit_addr (commit_addr[PEER]),
      .peer_commit_data (commit_data[PEER]),
      .commit_en        (commit_en[g]),
      .commit_addr      (commit_addr[g]),
      .commit_data      (commit_data[g]),
      .rd_addr          (rd_addr),
      .rd_part          (part[g])
    );
  end

  // Recombine: the stored word is the XOR of both groups' parts.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = part[0][p] ^ part[1][p];
  end

endmodule

// File: rtl/xrf_regfile_chk.sv
// Protocol and pipeline checks, attached to the top by bind.
module xrf_regfile_chk #(
  parameter int AW = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               wr0_en,
  input logic [AW-1:0]      wr0_addr,
  input logic               wr1_en,
  input logic [AW-1:0]      wr1_addr,
  input logic [1:0]         commit_en,
  input logic [1:0][AW-1:0] commit_addr
);

  // R6: both ports may not target one address in the same cycle.
  p_distinct_waddr_r6: assert property (@(posedge clk) disable iff (rst)
    (wr0_en && wr1_en) |-> (wr0_addr != wr1_addr));

  // R3: an accepted write is stored exactly one cycle after it is issued.
  p_commit_after_req0_r3: assert property (@(posedge clk) disable iff (rst)
    wr0_en |=> commit_en[0]);
  p_commit_after_req1_r3: assert property (@(posedge clk) disable iff (rst)
    wr1_en |=> commit_en[1]);

  // R3: the store lands at the address issued in the previous cycle.
  p_commit_addr0_r3: assert property (@(posedge clk) disable iff (rst)
    commit_en[0] |-> (commit_addr[0] == $past(wr0_addr)));
  p_commit_addr1_r3: assert property (@(posedge clk) disable iff (rst)
    commit_en[1] |-> (commit_addr[1] == $past(wr1_addr)));

  // R8: an idle write port produces no store.
  p_no_commit_idle0_r8: assert property (@(posedge clk) disable iff (rst)
    !wr0_en |=> !commit_en[0]);
  p_no_commit_idle1_r8: assert property (@(posedge clk) disable iff (rst)
    !wr1_en |=> !commit_en[1]);

endmodule

bind xrf_regfile xrf_regfile_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr0_en      (wr0_en),
  .wr0_addr    (wr0_addr),
  .wr1_en      (wr1_en),
  .wr1_addr    (wr1_addr),
  .commit_en   (commit_en),
  .commit_addr (commit_addr)
);

// File: tb/xrf_regfile_tb.sv
`timescale 1ns/1ps
module xrf_regfile_tb;

  localparam int DEPTH = 32;
  localparam int WIDTH = 32;
  localparam int NRD   = 4;
  localparam int AW    = $clog2(DEPTH);

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic                      wr0_en = 1'b0;
  logic [AW-1:0]             wr0_addr = '0;
  logic [WIDTH-1:0]          wr0_data = '0;
  logic                      wr1_en = 1'b0;
  logic [AW-1:0]             wr1_addr = '0;
  logic [WIDTH-1:0]          wr1_data = '0;
  logic [NRD-1:0][AW-1:0]    rd_addr = '0;
  logic [NRD-1:0][WIDTH-1:0] rd_data;

  always #4 clk = ~clk;  // 125 MHz

  xrf_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD)) u_dut (
    .clk(clk), .rst(rst),
    .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // ---------------- behavioural reference ----------------
  logic [WIDTH-1:0] mdl [DEPTH];
  bit               known [DEPTH];
  logic [WIDTH-1:0] exp_d [NRD];
  bit               exp_k [NRD];
  bit               pend_v [2];
  logic [AW-1:0]    pend_a [2];
  logic [WIDTH-1:0] pend_d [2];

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string cur_req = "R7";

  initial begin
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
    for (int p = 0; p < NRD; p++) exp_k[p] = 1'b0;
    for (int k = 0; k < 2; k++) pend_v[k] = 1'b0;
  end

  // Reads sample the array before this edge's stores; a write issued in one
  // cycle is applied on the edge closing the following cycle.
  always @(posedge clk) begin
    for (int p = 0; p < NRD; p++) begin
      exp_d[p] = mdl[rd_addr[p]];
      exp_k[p] = known[rd_addr[p]];
    end
    for (int k = 0; k < 2; k++) begin
      if (pend_v[k]) begin
        mdl[pend_a[k]]   = pend_d[k];
        known[pend_a[k]] = 1'b1;
      end
    end
    pend_v[0] = wr0_en && !rst; pend_a[0] = wr0_addr; pend_d[0] = wr0_data;
    pend_v[1] = wr1_en && !rst; pend_a[1] = wr1_addr; pend_d[1] = wr1_data;
  end

  task automatic compare_outputs();
    for (int p = 0; p < NRD; p++) begin
      if (exp_k[p]) begin
        n_cmp++;
        if (rd_data[p] !== exp_d[p]) begin
          n_bad++;
          $display("FAIL %s read port %0d: actual=%h expected=%h (t=%0t)",
                   cur_req, p, rd_data[p], exp_d[p], $time);
        end
      end
    end
  endtask

  // One cycle: check outputs away from the edge, then drive new inputs.
  task automatic step(input bit we0, input int a0, input logic [WIDTH-1:0] d0,
                      input bit we1, input int a1, input logic [WIDTH-1:0] d1,
                      input int r0, input int r1, input int r2, input int r3);
    @(negedge clk);
    compare_outputs();
    wr0_en = we0; wr0_addr = AW'(a0); wr0_data = d0;
    wr1_en = we1; wr1_addr = AW'(a1); wr1_data = d1;
    rd_addr[0] = AW'(r0); rd_addr[1] = AW'(r1);
    rd_addr[2] = AW'(r2); rd_addr[3] = AW'(r3);
  endtask

  task automatic idle_read(input int a, input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, '0, a, a, a, a);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) step(0, 0, '0, 0, 0, '0, 0, 1, 2, 3);
    @(negedge clk); rst = 1'b0;

    // R6: fill every word with simultaneous writes to distinct addresses.
    cur_req = "R6";
    for (int i = 0; i < DEPTH / 2; i++)
      step(1, 2 * i, 32'hA000_0000 + i, 1, 2 * i + 1, 32'hB000_0000 + i,
           0, 1, 2, 3);
    step(0, 0, '0, 0, 0, '0, 0, 1, 30, 31);
    step(0, 0, '0, 0, 0, '0, 5, 6, 17, 18);
    step(0, 0, '0, 0, 0, '0, 7, 8, 9, 10);

    // R7: writes offered during reset are dropped; contents survive reset.
    cur_req = "R7";
    @(negedge clk);
    compare_outputs();
    rst = 1'b1;
    wr0_en = 1; wr0_addr = 5; wr0_data = 32'hDEAD_BEEF;
    wr1_en = 1; wr1_addr = 6; wr1_data = 32'hFEED_F00D;
    step(1, 5, 32'h1111_1111, 1, 6, 32'h2222_2222, 5, 6, 5, 6);
    @(negedge clk);
    compare_outputs();
    rst = 1'b0; wr0_en = 0; wr1_en = 0;
    idle_read(5, 2);
    idle_read(6, 2);

    // R3: read the write address in the write cycle and the next cycles.
    cur_req = "R3";
    step(1, 7, 32'h7777_0001, 0, 0, '0, 7, 7, 7, 7);
    idle_read(7, 4);
    step(0, 0, '0, 1, 8, 32'h8888_0002, 8, 8, 8, 8);
    idle_read(8, 4);

    // R4: cross-port writes to one address on consecutive cycles, both orders.
    cur_req = "R4";
    step(0, 0, '0, 1, 9, 32'h0909_0B0B, 9, 9, 9, 9);
    step(1, 9, 32'h0909_0A0A, 0, 0, '0, 9, 9, 9, 9);
    idle_read(9, 4);
    step(1, 10, 32'h1010_0A0A, 0, 0, '0, 10, 10, 10, 10);
    step(0, 0, '0, 1, 10, 32'h1010_0B0B, 10, 10, 10, 10);
    idle_read(10, 4);
    // cross-port chain with both ports busy each cycle
    step(1, 11, 32'hC0DE_0001, 1, 12, 32'hC0DE_0002, 11, 12, 11, 12);
    step(1, 12, 32'hC0DE_0003, 1, 11, 32'hC0DE_0004, 11, 12, 11, 12);
    idle_read(11, 2);
    idle_read(12, 2);

    // R5: one port writing the same address on consecutive cycles.
    cur_req = "R5";
    step(1, 13, 32'h1313_0001, 0, 0, '0, 13, 13, 13, 13);
    step(1, 13, 32'h1313_0002, 0, 0, '0, 13, 13, 13, 13);
    step(1, 13, 32'h1313_0003, 0, 0, '0, 13, 13, 13, 13);
    idle_read(13, 3);
    step(0, 0, '0, 1, 14, 32'h1414_0001, 14, 14, 14, 14);
    step(0, 0, '0, 1, 14, 32'h1414_0002, 14, 14, 14, 14);
    idle_read(14, 3);

    // R8: disabled ports with busy address and data change nothing.
    cur_req = "R8";
    for (int i = 0; i < 8; i++)
      step(0, 15 + i, $urandom, 0, 16 + i, $urandom, 15 + i, 16 + i, 15, 16);
    idle_read(15, 2);
    idle_read(20, 2);

    // R1 / R2: every port active, fresh read addresses every cycle.
    cur_req = "R1";
    for (int i = 0; i < 4000; i++) begin
      int a0, a1;
      a0 = int'($urandom % DEPTH);
      a1 = int'($urandom % DEPTH);
      if (a1 == a0) a1 = (a0 + 1) % DEPTH;  // same-address pair is illegal (R6)
      if (i == 2000) cur_req = "R2";
      step(($urandom % 4) != 0, a0, $urandom,
           ($urandom % 4) != 0, a1, $urandom,
           int'($urandom % DEPTH), int'($urandom % DEPTH),
           int'($urandom % DEPTH), int'($urandom % DEPTH));
    end
    cur_req = "R3";
    idle_read(0, 3);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Watchdog: a hung run is counted as a failed check.
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule